// File: doc/BRIEF.md
# LCD Panel Power and Mode Sequencer

This block drives a small serially attached LCD panel by issuing command requests, one at a time, to a frame serializer. The commands live in a small read-only table made of short lists, each closed by a terminator entry. A power-on, a power-off or a resolution change is carried out by walking a fixed chain of these lists. Each entry carries an opcode, a parameter count of zero to two and up to two parameter bytes. The serializer turns each request into a frame and answers with a done pulse, which may carry an error flag.

The block watches three inputs: a requested power state, a requested resolution (full or quarter) and a per-panel colour-invert enable. It starts work only when a request differs from the state it holds. The stored power state and stored resolution change only when a chain finishes cleanly. When the invert enable is low, the plain invert command is filtered out of any list while the list is being walked. After reset the block holds power off and full resolution, and it then runs a power-on chain by itself.

The controller has five states. IDLE waits for work: a power crossing or the boot flag starts a chain, and otherwise a resolution mismatch starts one. LOAD points the table address at the next list of the chain; when no list is left it commits the new state and returns to IDLE. FETCH examines the current entry. A terminator moves on to LOAD with the next step, a filtered invert entry steps the address, and any other entry moves to SEND. SEND raises the request for one cycle. WAIT holds until done: a clean done steps the address and returns to FETCH, and done with error aborts to IDLE.

Top module: `lcd_panel_sequencer`

## Requirements
- R1: While reset is asserted, busy=0, cmd_valid=0, pwr_state=0 and mode_full=1. After reset is released, a power-on chain starts by itself in the first cycle.
- R2: A power-on chain issues the panel-on list (0x29; 0xB8 with 0xFF,0xF9; 0x11; 0xB0 with 0x16), then the reset list (0x01 and then three 0x00), then the mode setup for the stored resolution, and it ends with pwr_state=1.
- R3: A power-off chain issues only 0x28; 0xB8 with 0x80,0x02; 0x10; 0xB0 with 0x00, and it ends with pwr_state=0.
- R4: A mode setup for full resolution (mode_full=1) issues the full pass-through list (0xBC 0x80; 0x3B 0x00; 0x36 0x50), then the shared list, then the full timing list (0xD0 0x08,0x04; 0xD1 0x01; 0x21; 0x29).
- R5: A mode setup for quarter resolution issues the quarter pass-through list (0xBC 0x81; 0x3B 0x22; 0x36 0x50), then the shared list, then the quarter timing list (0xD7 0x08,0x04; 0xD8 0x01; 0x21; 0x29).
- R6: The shared configuration list is 0x3A 0x60; 0xB1 0x56; 0xB6 0x40; 0xEC 0x01,0xF0. Unused parameter bytes are driven as 0x00.
- R7: A power request equal to pwr_state issues no command and leaves busy low.
- R8: A resolution request equal to mode_full is ignored. mode_full changes only when its chain completes, so it keeps its old value while busy.
- R9: With inv_en=0, the zero-parameter opcode 0x21 is skipped wherever it appears. With inv_en=1 it is issued.
- R10: cmd_valid is a one-cycle pulse. cmd_op, cmd_nparam, cmd_p0 and cmd_p1 stay stable until ser_done, and no new request is made before ser_done.
- R11: ser_done together with ser_err ends the whole chain at once, leaves pwr_state and mode_full unchanged and drops busy.
- R12: busy is high from the start of a chain to its end. Requests are sampled only while busy is low, and a power crossing takes priority over a resolution change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Requested power state, 1 = on |
| mode_full_req | input | 1 | Requested resolution, 1 = full, 0 = quarter |
| inv_en | input | 1 | Colour-invert enable for this panel |
| cmd_valid | output | 1 | One-cycle command request to the serializer |
| cmd_nparam | output | 2 | Parameter count of the command |
| cmd_op | output | 8 | Command opcode |
| cmd_p0 | output | 8 | First parameter byte |
| cmd_p1 | output | 8 | Second parameter byte |
| ser_done | input | 1 | Serializer finished the current command |
| ser_err | input | 1 | Qualifies ser_done as a failed transfer |
| busy | output | 1 | A chain is in progress |
| pwr_state | output | 1 | Stored power state |
| mode_full | output | 1 | Stored resolution, 1 = full |

## Verification
A wrong table address or chain step shows up at the ports on the very next request: the opcode or parameters differ from the expected chain, so the first command after the fault exposes it. A stored power or resolution bit that is updated early, updated late or never updated shows on pwr_state or mode_full in the cycle busy falls. It can also show one cycle later, when a spurious chain starts or an expected one does not. A broken invert filter or a broken hold-off changes the command count of the chain at once, so the log comparison at the end of each chain finds it.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam int OP_W      = 8;
    localparam int ROM_DEPTH = 38;
    localparam int ROM_AW    = $clog2(ROM_DEPTH);
    localparam int STEP_W    = 3;
    localparam logic [OP_W-1:0] INV_OP = 8'h21;

    typedef struct packed {
        logic            last;
        logic [1:0]      nparam;
        logic [OP_W-1:0] op;
        logic [OP_W-1:0] p0;
        logic [OP_W-1:0] p1;
    } rom_word_t;

    typedef enum logic [1:0] {
        KIND_ON   = 2'd0,
        KIND_OFF  = 2'd1,
        KIND_MODE = 2'd2
    } seq_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_FETCH = 3'd2,
        ST_SEND  = 3'd3,
        ST_WAIT  = 3'd4
    } seq_state_t;

    // start address of each list in the command table
    localparam logic [ROM_AW-1:0] BASE_ON      = ROM_AW'(0);
    localparam logic [ROM_AW-1:0] BASE_RST     = ROM_AW'(5);
    localparam logic [ROM_AW-1:0] BASE_OFF     = ROM_AW'(10);
    localparam logic [ROM_AW-1:0] BASE_PT_FULL = ROM_AW'(15);
    localparam logic [ROM_AW-1:0] BASE_PT_QTR  = ROM_AW'(19);
    localparam logic [ROM_AW-1:0] BASE_CFG     = ROM_AW'(23);
    localparam logic [ROM_AW-1:0] BASE_TX_FULL = ROM_AW'(28);
    localparam logic [ROM_AW-1:0] BASE_TX_QTR  = ROM_AW'(33);

endpackage

// File: rtl/lcdseq_rom.sv
module lcdseq_rom
    import lcdseq_pkg::*;
(
    input  logic [ROM_AW-1:0] addr,
    output rom_word_t         word
);

    function automatic rom_word_t ent(input logic [1:0] np, input logic [7:0] op,
                                      input logic [7:0] a, input logic [7:0] b);
        rom_word_t w;
        w.last   = 1'b0;
        w.nparam = np;
        w.op     = op;
        w.p0     = a;
        w.p1     = b;
        return w;
    endfunction

    localparam rom_word_t TERM = '{last: 1'b1, nparam: 2'd0, op: 8'h00, p0: 8'h00, p1: 8'h00};

    always_comb begin
        case (int'(addr))
            // panel on
            0:  word = ent(2'd0, 8'h29, 8'h00, 8'h00);
            1:  word = ent(2'd2, 8'hB8, 8'hFF, 8'hF9);
            2:  word = ent(2'd0, 8'h11, 8'h00, 8'h00);
            3:  word = ent(2'd1, 8'hB0, 8'h16, 8'h00);
            // soft reset and settle
            5:  word = ent(2'd0, 8'h01, 8'h00, 8'h00);
            6:  word = ent(2'd0, 8'h00, 8'h00, 8'h00);
            7:  word = ent(2'd0, 8'h00, 8'h00, 8'h00);
            8:  word = ent(2'd0, 8'h00, 8'h00, 8'h00);
            // panel off
            10: word = ent(2'd0, 8'h28, 8'h00, 8'h00);
            11: word = ent(2'd2, 8'hB8, 8'h80, 8'h02);
            12: word = ent(2'd0, 8'h10, 8'h00, 8'h00);
            13: word = ent(2'd1, 8'hB0, 8'h00, 8'h00);
            // full-resolution pass-through
            15: word = ent(2'd1, 8'hBC, 8'h80, 8'h00);
            16: word = ent(2'd1, 8'h3B, 8'h00, 8'h00);
            17: word = ent(2'd1, 8'h36, 8'h50, 8'h00);
            // quarter-resolution pass-through
            19: word = ent(2'd1, 8'hBC, 8'h81, 8'h00);
            20: word = ent(2'd1, 8'h3B, 8'h22, 8'h00);
            21: word = ent(2'd1, 8'h36, 8'h50, 8'h00);
            // shared configuration
            23: word = ent(2'd1, 8'h3A, 8'h60, 8'h00);
            24: word = ent(2'd1, 8'hB1, 8'h56, 8'h00);
            25: word = ent(2'd1, 8'hB6, 8'h40, 8'h00);
            26: word = ent(2'd2, 8'hEC, 8'h01, 8'hF0);
            // full-resolution timing
            28: word = ent(2'd2, 8'hD0, 8'h08, 8'h04);
            29: word = ent(2'd1, 8'hD1, 8'h01, 8'h00);
            30: word = ent(2'd0, INV_OP, 8'h00, 8'h00);
            31: word = ent(2'd0, 8'h29, 8'h00, 8'h00);
            // quarter-resolution timing
            33: word = ent(2'd2, 8'hD7, 8'h08, 8'h04);
            34: word = ent(2'd1, 8'hD8, 8'h01, 8'h00);
            35: word = ent(2'd0, INV_OP, 8'h00, 8'h00);
            36: word = ent(2'd0, 8'h29, 8'h00, 8'h00);
            default: word = TERM;
        endcase
    end

endmodule

// File: rtl/lcdseq_chain.sv
module lcdseq_chain
    import lcdseq_pkg::*;
(
    input  seq_kind_t          kind,
    input  logic [STEP_W-1:0]  step,
    input  logic               full,
    output logic               ok,
    output logic [ROM_AW-1:0]  base
);

    // power-on uses steps 0..4, a mode change enters the same table at step 2
    always_comb begin
        ok   = 1'b1;
        base = BASE_OFF;
        if (kind == KIND_OFF) begin
            ok = (step == '0);
        end else begin
            case (int'(step))
                0:       base = BASE_ON;
                1:       base = BASE_RST;
                2:       base = full ? BASE_PT_FULL : BASE_PT_QTR;
                3:       base = BASE_CFG;
                4:       base = full ? BASE_TX_FULL : BASE_TX_QTR;
                default: ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
    import lcdseq_pkg::*;
#(
    parameter bit BOOT_ON = 1'b1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_req,
    input  logic               mode_full_req,
    input  logic               inv_en,
    input  logic               ser_done,
    input  logic               ser_err,
    input  logic               ent_last,
    input  logic [1:0]         ent_np,
    input  logic [OP_W-1:0]    ent_op,
    input  logic               list_ok,
    input  logic [ROM_AW-1:0]  list_base,
    output seq_kind_t          kind,
    output logic [STEP_W-1:0]  step,
    output logic               tgt_full,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               busy,
    output logic               cmd_valid,
    output logic               pwr_state,
    output logic               mode_full
);

    seq_state_t          state_q, state_d;
    seq_kind_t           kind_q, kind_d;
    logic [STEP_W-1:0]   step_q, step_d;
    logic [ROM_AW-1:0]   ptr_q, ptr_d;
    logic                tgt_q, tgt_d;
    logic                pwr_q, pwr_d;
    logic                mode_q, mode_d;
    logic                boot_q, boot_d;
    logic                skip_ent;

    assign skip_ent = (ent_op == INV_OP) && (ent_np == 2'd0) && !inv_en;

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        step_d  = step_q;
        ptr_d   = ptr_q;
        tgt_d   = tgt_q;
        pwr_d   = pwr_q;
        mode_d  = mode_q;
        boot_d  = boot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (boot_q || (pwr_req && !pwr_q)) begin
                    kind_d  = KIND_ON;
                    step_d  = '0;
                    tgt_d   = mode_q;
                    boot_d  = 1'b0;
                    state_d = ST_LOAD;
                end else if (!pwr_req && pwr_q) begin
                    kind_d  = KIND_OFF;
                    step_d  = '0;
                    state_d = ST_LOAD;
                end else if (mode_full_req != mode_q) begin
                    kind_d  = KIND_MODE;
                    step_d  = STEP_W'(2);
                    tgt_d   = mode_full_req;
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (list_ok) begin
                    ptr_d   = list_base;
                    state_d = ST_FETCH;
                end else begin
                    unique case (kind_q)
                        KIND_ON:  begin pwr_d = 1'b1; mode_d = tgt_q; end
                        KIND_OFF: pwr_d = 1'b0;
                        default:  mode_d = tgt_q;
                    endcase
                    state_d = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (ent_last) begin
                    step_d  = step_q + STEP_W'(1);
                    state_d = ST_LOAD;
                end else if (skip_ent) begin
                    ptr_d   = ptr_q + ROM_AW'(1);
                end else begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: state_d = ST_WAIT;
            ST_WAIT: begin
                if (ser_done) begin
                    if (ser_err) begin
                        state_d = ST_IDLE;
                    end else begin
                        ptr_d   = ptr_q + ROM_AW'(1);
                        state_d = ST_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_ON;
            step_q  <= '0;
            ptr_q   <= '0;
            tgt_q   <= 1'b1;
            pwr_q   <= 1'b0;
            mode_q  <= 1'b1;
            boot_q  <= BOOT_ON;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            step_q  <= step_d;
            ptr_q   <= ptr_d;
            tgt_q   <= tgt_d;
            pwr_q   <= pwr_d;
            mode_q  <= mode_d;
            boot_q  <= boot_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        cmd_valid = (state_q == ST_SEND);
        pwr_state = pwr_q;
        mode_full = mode_q;
        kind      = kind_q;
        step      = step_q;
        tgt_full  = tgt_q;
        rom_addr  = ptr_q;
    end

endmodule

// File: rtl/lcd_panel_sequencer.sv
module lcd_panel_sequencer
    import lcdseq_pkg::*;
#(
    parameter bit BOOT_ON = 1'b1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_req,
    input  logic             mode_full_req,
    input  logic             inv_en,
    output logic             cmd_valid,
    output logic [1:0]       cmd_nparam,
    output logic [OP_W-1:0]  cmd_op,
    output logic [OP_W-1:0]  cmd_p0,
    output logic [OP_W-1:0]  cmd_p1,
    input  logic             ser_done,
    input  logic             ser_err,
    output logic             busy,
    output logic             pwr_state,
    output logic             mode_full
);

    rom_word_t          word;
    seq_kind_t          kind;
    logic [STEP_W-1:0]  step;
    logic               tgt_full;
    logic [ROM_AW-1:0]  rom_addr;
    logic               list_ok;
    logic [ROM_AW-1:0]  list_base;

    lcdseq_rom u_rom (
        .addr (rom_addr),
        .word (word)
    );

    lcdseq_chain u_chain (
        .kind (kind),
        .step (step),
        .full (tgt_full),
        .ok   (list_ok),
        .base (list_base)
    );

    lcdseq_ctrl #(.BOOT_ON(BOOT_ON)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_req       (pwr_req),
        .mode_full_req (mode_full_req),
        .inv_en        (inv_en),
        .ser_done      (ser_done),
        .ser_err       (ser_err),
        .ent_last      (word.last),
        .ent_np        (word.nparam),
        .ent_op        (word.op),
        .list_ok       (list_ok),
        .list_base     (list_base),
        .kind          (kind),
        .step          (step),
        .tgt_full      (tgt_full),
        .rom_addr      (rom_addr),
        .busy          (busy),
        .cmd_valid     (cmd_valid),
        .pwr_state     (pwr_state),
        .mode_full     (mode_full)
    );

    assign cmd_nparam = word.nparam;
    assign cmd_op     = word.op;
    assign cmd_p0     = word.p0;
    assign cmd_p1     = word.p1;

endmodule

// File: rtl/lcdseq_checker.sv
module lcdseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cmd_valid,
    input logic [1:0] cmd_nparam,
    input logic [7:0] cmd_op,
    input logic       inv_en,
    input logic       pwr_state,
    input logic       mode_full
);

    AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R12

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R10

    AST_PWR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(pwr_state))); // R12

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(mode_full))); // R8

    AST_INVERT_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !inv_en) |-> !(cmd_op == 8'h21 && cmd_nparam == 2'd0)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(pwr_state) && $stable(mode_full))); // R7

endmodule

bind lcd_panel_sequencer lcdseq_checker i_lcdseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_nparam (cmd_nparam),
    .cmd_op     (cmd_op),
    .inv_en     (inv_en),
    .pwr_state  (pwr_state),
    .mode_full  (mode_full)
);

// File: tb/test_lcd_panel_sequencer.sv
`timescale 1ns/1ps
module test_lcd_panel_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_req = 1'b1;
    logic       mode_full_req = 1'b1;
    logic       inv_en = 1'b1;
    logic       ser_done = 1'b0;
    logic       ser_err = 1'b0;
    logic       cmd_valid, busy, pwr_state, mode_full;
    logic [1:0] cmd_nparam;
    logic [7:0] cmd_op, cmd_p0, cmd_p1;

    always #2.5 clk = ~clk;

    lcd_panel_sequencer i_lcd_panel_sequencer (
        .clk (clk), .rst_n (rst_n), .pwr_req (pwr_req), .mode_full_req (mode_full_req),
        .inv_en (inv_en), .cmd_valid (cmd_valid), .cmd_nparam (cmd_nparam),
        .cmd_op (cmd_op), .cmd_p0 (cmd_p0), .cmd_p1 (cmd_p1), .ser_done (ser_done),
        .ser_err (ser_err), .busy (busy), .pwr_state (pwr_state), .mode_full (mode_full)
    );

    int n_chk = 0;
    int n_bad = 0;
    int done_flag = 0;

    logic [7:0] l_op [64];
    logic [1:0] l_np [64];
    logic [7:0] l_p0 [64];
    logic [7:0] l_p1 [64];
    int         l_cnt = 0;
    logic [7:0] e_op [64];
    logic [1:0] e_np [64];
    logic [7:0] e_p0 [64];
    logic [7:0] e_p1 [64];
    int         e_cnt = 0;
    int         err_at = -1;
    int         hold_viol = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (done_flag == 0) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // serializer model: log each request, hold it a few cycles, then answer
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                logic [7:0] op_s, p0_s, p1_s;
                logic [1:0] np_s;
                int idx;
                op_s = cmd_op; np_s = cmd_nparam; p0_s = cmd_p0; p1_s = cmd_p1;
                idx = l_cnt;
                if (l_cnt < 64) begin
                    l_op[l_cnt] = op_s; l_np[l_cnt] = np_s;
                    l_p0[l_cnt] = p0_s; l_p1[l_cnt] = p1_s;
                end
                l_cnt++;
                repeat (2) begin
                    @(negedge clk);
                    if (cmd_valid || cmd_op != op_s || cmd_nparam != np_s ||
                        cmd_p0 != p0_s || cmd_p1 != p1_s)
                        hold_viol++;
                end
                ser_err  = (idx == err_at);
                ser_done = 1'b1;
                @(negedge clk);
                ser_done = 1'b0;
                ser_err  = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    task automatic push(input logic [1:0] np, input logic [7:0] op,
                        input logic [7:0] a, input logic [7:0] b);
        e_op[e_cnt] = op; e_np[e_cnt] = np; e_p0[e_cnt] = a; e_p1[e_cnt] = b;
        e_cnt++;
    endtask

    task automatic exp_panel_on();      // R2
        push(0, 8'h29, 0, 0); push(2, 8'hB8, 8'hFF, 8'hF9);
        push(0, 8'h11, 0, 0); push(1, 8'hB0, 8'h16, 0);
    endtask
    task automatic exp_reset_list();    // R2
        push(0, 8'h01, 0, 0);
        for (int i = 0; i < 3; i++) push(0, 8'h00, 0, 0);
    endtask
    task automatic exp_mode(input bit full, input bit inv); // R4 R5 R6 R9
        if (full) begin
            push(1, 8'hBC, 8'h80, 0); push(1, 8'h3B, 8'h00, 0); push(1, 8'h36, 8'h50, 0);
        end else begin
            push(1, 8'hBC, 8'h81, 0); push(1, 8'h3B, 8'h22, 0); push(1, 8'h36, 8'h50, 0);
        end
        push(1, 8'h3A, 8'h60, 0); push(1, 8'hB1, 8'h56, 0);
        push(1, 8'hB6, 8'h40, 0); push(2, 8'hEC, 8'h01, 8'hF0);
        if (full) begin
            push(2, 8'hD0, 8'h08, 8'h04); push(1, 8'hD1, 8'h01, 0);
        end else begin
            push(2, 8'hD7, 8'h08, 8'h04); push(1, 8'hD8, 8'h01, 0);
        end
        if (inv) push(0, 8'h21, 0, 0);
        push(0, 8'h29, 0, 0);
    endtask
    task automatic exp_panel_off();     // R3
        push(0, 8'h28, 0, 0); push(2, 8'hB8, 8'h80, 8'h02);
        push(0, 8'h10, 0, 0); push(1, 8'hB0, 8'h00, 0);
    endtask

    task automatic compare_log(input string req);
        check(l_cnt == e_cnt, req, "command count", l_cnt, e_cnt);
        for (int i = 0; i < e_cnt && i < l_cnt; i++) begin
            check(l_op[i] == e_op[i], req, $sformatf("opcode #%0d", i), l_op[i], e_op[i]);
            check(l_np[i] == e_np[i] && l_p0[i] == e_p0[i] && l_p1[i] == e_p1[i], req,
                  $sformatf("params #%0d", i),
                  {l_np[i], l_p0[i], l_p1[i]}, {e_np[i], e_p0[i], e_p1[i]});
        end
    endtask

    task automatic clear_logs();
        l_cnt = 0;
        e_cnt = 0;
    endtask

    task automatic wait_chain_end(input string req);
        int t;
        t = 0;
        while (!busy && t < 10) begin @(negedge clk); t++; end
        check(busy == 1'b1, req, "busy rise", busy, 1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_quiet(input string req);
        int seen;
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (busy) seen++;
        end
        check(seen == 0, req, "busy cycles", seen, 0);
        check(l_cnt == 0, req, "commands issued", l_cnt, 0);
    endtask

    task automatic t_reset_boot();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(cmd_valid == 0, "R1", "cmd_valid in reset", cmd_valid, 0);
        check(pwr_state == 0, "R1", "pwr_state in reset", pwr_state, 0);
        check(mode_full == 1, "R1", "mode_full in reset", mode_full, 1);
        clear_logs();
        exp_panel_on(); exp_reset_list(); exp_mode(1'b1, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1, "R1", "auto power-on start", busy, 1);
        wait_chain_end("R1");
        compare_log("R2");
        check(pwr_state == 1, "R2", "pwr_state after on", pwr_state, 1);
        check(mode_full == 1, "R4", "mode after boot", mode_full, 1);
        check(hold_viol == 0, "R10", "request hold violations", hold_viol, 0);
    endtask

    task automatic t_same_power();
        clear_logs();
        pwr_req = 1'b1;
        wait_quiet("R7");
    endtask

    task automatic t_mode_quarter_noinv();
        clear_logs();
        inv_en = 1'b0;
        exp_mode(1'b0, 1'b0);
        mode_full_req = 1'b0;
        repeat (6) @(negedge clk);
        check(busy == 1 && mode_full == 1, "R8", "mode held while busy",
              {busy, mode_full}, 2'b11);
        wait_chain_end("R5");
        compare_log("R9");
        check(mode_full == 0, "R5", "mode after quarter chain", mode_full, 0);
    endtask

    task automatic t_same_mode();
        clear_logs();
        mode_full_req = 1'b0;
        wait_quiet("R8");
    endtask

    task automatic t_power_off();
        clear_logs();
        exp_panel_off();
        pwr_req = 1'b0;
        wait_chain_end("R3");
        compare_log("R3");
        check(pwr_state == 0, "R3", "pwr_state after off", pwr_state, 0);
        clear_logs();
        wait_quiet("R7");
    endtask

    task automatic t_power_on_quarter();
        clear_logs();
        inv_en = 1'b1;
        exp_panel_on(); exp_reset_list(); exp_mode(1'b0, 1'b1);
        pwr_req = 1'b1;
        wait_chain_end("R2");
        compare_log("R2");
        check(pwr_state == 1 && mode_full == 0, "R2", "state after on",
              {pwr_state, mode_full}, 2'b10);
    endtask

    task automatic t_holdoff();
        clear_logs();
        exp_mode(1'b1, 1'b1);
        mode_full_req = 1'b1;
        repeat (4) @(negedge clk);
        pwr_req = 1'b0;
        repeat (3) @(negedge clk);
        pwr_req = 1'b1;
        wait_chain_end("R12");
        compare_log("R12");
        check(pwr_state == 1 && mode_full == 1, "R12", "state after held-off request",
              {pwr_state, mode_full}, 2'b11);
        check(hold_viol == 0, "R10", "request hold violations", hold_viol, 0);
    endtask

    task automatic t_error_abort();
        clear_logs();
        push(0, 8'h28, 0, 0); push(2, 8'hB8, 8'h80, 8'h02);
        err_at = 1;
        pwr_req = 1'b0;
        repeat (3) @(negedge clk);
        pwr_req = 1'b1;
        wait_chain_end("R11");
        err_at = -1;
        compare_log("R11");
        check(pwr_state == 1, "R11", "pwr_state kept after error", pwr_state, 1);
        check(busy == 0, "R11", "busy after error", busy, 0);
        clear_logs();
        wait_quiet("R11");
    endtask

    initial begin
        t_reset_boot();
        t_same_power();
        t_mode_quarter_noinv();
        t_same_mode();
        t_power_off();
        t_power_on_quarter();
        t_holdoff();
        t_error_abort();
        finish_up();
    end

endmodule